// File: doc/BRIEF.md
# Byte-Coded Multicycle Processor Core

This block is a small multicycle processor with 8-bit data and 8-bit addresses. It reads its program one byte at a time over a single synchronous byte-wide memory port. The port carries an address, write data and a write strobe, and read data comes back one clock after the address is presented. Instructions are two or three bytes long: an opcode byte followed by one or two operand bytes. Each operand byte carries its own addressing mode, so both the fetch length and the way each operand is resolved change from one instruction to the next.

The visible state is a program counter and two general registers. The core can move data, shift, add, subtract, increment, decrement, and branch on zero, on negative or unconditionally. It stops for good when it meets an opcode it does not know or an operand combination it cannot execute. It then raises a halt output and a cause flag, and it keeps them until reset.

Top module: `octet_core`

## Requirements
- R1: Reset is synchronous and active low. While reset is held and after it is released, the first fetch is from address 0x00, the write strobe is low, and `halted`, `bad_opcode` and `bad_operand` are low.
- R2: Opcodes 14 (decrement), 15 (increment) and 50 (branch always) occupy 2 bytes. Opcodes 8, 10, 11, 12, 13, 48 and 49 occupy 3 bytes. The next instruction starts at the byte after the last operand byte.
- R3: An operand byte has its mode in bits [7:6] and its field in bits [5:0]. Mode 00 is the field sign-extended to 8 bits. Mode 01 is register R0 or R1, chosen by field bit 0. Mode 10 is memory at the chosen register plus field bits [5:1], zero-extended. Mode 11 is the address of the next instruction plus the sign-extended field, modulo 256; data operands in this mode read and write memory at that address.
- R4: Opcode 8 copies the value of the second operand into the first operand, which may be a register or a memory byte.
- R5: Opcode 12 adds the second operand to the first, and opcode 13 subtracts the second operand from the first. Both work modulo 256 and write the result to the first operand, which must be a register.
- R6: Opcode 10 shifts the first operand right arithmetically (bit 7 is replicated), and opcode 11 shifts it left, filling with zeros. The shift is in place, and the count is the low 3 bits of the second operand, so a count of 0 leaves the value unchanged.
- R7: Opcode 15 increments and opcode 14 decrements its single operand in place, wrapping modulo 256, in a register or in memory.
- R8: Opcode 48 branches when the first operand is zero. Opcode 49 branches when bit 7 of the first operand is set. In both cases the target is the address formed by the second operand. Opcode 50 always branches to the address formed by its single operand. A branch that is not taken continues with the next instruction.
- R9: Any other opcode value sets `halted` and `bad_opcode`. After that the core fetches nothing more, writes nothing, and holds its outputs until reset.
- R10: Three cases set `halted` and `bad_operand` instead of executing the instruction: a destination in mode 00, a first operand of opcode 12 or 13 in mode 10 or 11, or a branch target in any mode other than 11. The instruction that causes it has no effect.
- R11: An instruction writes memory at most once, only when its first operand is a memory destination. The write goes to that operand's address and carries the result, as a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Byte address for fetch, operand load or store |
| mem_wdata | output | 8 | Store data, valid while `mem_we` is high |
| mem_we | output | 1 | Write strobe for one cycle |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |
| halted | output | 1 | Core has stopped |
| bad_opcode | output | 1 | Stop caused by an unknown opcode |
| bad_operand | output | 1 | Stop caused by an operand mode the instruction forbids |

## Verification
The hardest case to reach from the ports is an operand that reads memory through mode 11. The address it forms depends on the length of the instruction that holds it, and the byte it reads may be part of the program itself. Stimulus reaches this case with small assembled programs. One of them loads its own operand byte through a negative offset and stores through a positive one. Another runs a countdown loop whose backward branch offset depends on the 2-byte length of the branch instruction. The register contents are never visible at the ports, so every program stores intermediate results to memory through modes 10 and 11. Each of those stores is checked against an instruction-level model.

// File: rtl/octet_pkg.sv
// Shared constants, encodings and opcode decode for the byte-coded core.
// Assumes 8-bit data and addresses with a 2-bit mode / 6-bit field operand.
package octet_pkg;

    localparam int DW      = 8;   // data and address width
    localparam int MODE_W  = 2;   // addressing-mode width in an operand byte
    localparam int FIELD_W = 6;   // value/address field width
    localparam int NOPND   = 2;   // operand bytes an instruction can carry
    localparam int IBYTES  = NOPND + 1;
    localparam int IDX_W   = $clog2(IBYTES);

    typedef enum logic [MODE_W-1:0] {
        AM_IMM = 2'b00,
        AM_REG = 2'b01,
        AM_IDX = 2'b10,
        AM_PCR = 2'b11
    } amode_t;

    typedef enum logic [DW-1:0] {
        OP_MOV = 8'd8,
        OP_ASR = 8'd10,
        OP_ASL = 8'd11,
        OP_ADD = 8'd12,
        OP_SUB = 8'd13,
        OP_DEC = 8'd14,
        OP_INC = 8'd15,
        OP_BRZ = 8'd48,
        OP_BRN = 8'd49,
        OP_BR  = 8'd50
    } opc_t;

    typedef struct packed {
        logic known;       // opcode is implemented
        logic three_byte;  // two operand bytes follow
        logic wr1;         // first operand is written back
        logic rd1;         // value of first operand is needed
        logic rd2;         // value of second operand is needed
        logic reg_dst;     // first operand must be a register
        logic is_br;       // instruction may redirect the PC
        logic tgt_on2;     // branch target is the second operand
    } dec_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_FWAIT,
        ST_CHECK,
        ST_LOAD,
        ST_LWAIT,
        ST_EXEC,
        ST_HALT
    } st_t;

    // Map an opcode byte to its control attributes.
    function automatic dec_t decode(input logic [DW-1:0] b);
        dec_t d;
        d = '0;
        case (b)
            OP_MOV: begin
                d.known = 1'b1; d.three_byte = 1'b1; d.wr1 = 1'b1; d.rd2 = 1'b1;
            end
            OP_ASR, OP_ASL: begin
                d.known = 1'b1; d.three_byte = 1'b1; d.wr1 = 1'b1;
                d.rd1 = 1'b1; d.rd2 = 1'b1;
            end
            OP_ADD, OP_SUB: begin
                d.known = 1'b1; d.three_byte = 1'b1; d.wr1 = 1'b1;
                d.rd1 = 1'b1; d.rd2 = 1'b1; d.reg_dst = 1'b1;
            end
            OP_DEC, OP_INC: begin
                d.known = 1'b1; d.wr1 = 1'b1; d.rd1 = 1'b1;
            end
            OP_BRZ, OP_BRN: begin
                d.known = 1'b1; d.three_byte = 1'b1; d.rd1 = 1'b1;
                d.is_br = 1'b1; d.tgt_on2 = 1'b1;
            end
            OP_BR: begin
                d.known = 1'b1; d.is_br = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

    // True when the byte is an implemented opcode.
    function automatic logic is_known(input logic [DW-1:0] b);
        dec_t d;
        d = decode(b);
        return d.known;
    endfunction

endpackage

// File: rtl/opnd_resolve.sv
// Operand resolver: turns one operand byte into its mode, a direct value
// (immediate or register) and an effective memory address.
// Assumes the next-instruction address is already known by the caller.
module opnd_resolve
    import octet_pkg::*;
(
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] r0,
    input  logic [DW-1:0] r1,
    input  logic [DW-1:0] next_pc,
    output amode_t        mode,
    output logic          is_mem,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] direct_val
);

    logic [FIELD_W-1:0] fld;
    logic [DW-1:0]      base;
    logic [DW-1:0]      sx;

    // Split the byte, pick the register and form both candidate addresses.
    always_comb begin
        fld        = opnd[FIELD_W-1:0];
        mode       = amode_t'(opnd[DW-1 -: MODE_W]);
        base       = fld[0] ? r1 : r0;
        sx         = {{(DW-FIELD_W){fld[FIELD_W-1]}}, fld};
        is_mem     = (mode == AM_IDX) || (mode == AM_PCR);
        ea         = (mode == AM_IDX) ? base + DW'(fld[FIELD_W-1:1])
                                      : next_pc + sx;
        direct_val = (mode == AM_REG) ? base : sx;
    end

endmodule

// File: rtl/exec_unit.sv
// Execute unit: computes the write-back value and the branch decision for
// the current opcode from the two resolved operand values.
// Assumes operands are already fetched; purely combinational.
module exec_unit
    import octet_pkg::*;
(
    input  logic [DW-1:0] opc,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] result,
    output logic          take
);

    localparam int            SH_W = $clog2(DW);
    localparam logic [DW-1:0] ONE  = DW'(1);

    logic [SH_W-1:0] cnt;

    // Select the result of the operation named by the opcode.
    always_comb begin
        cnt = b[SH_W-1:0];
        case (opc)
            OP_MOV:  result = b;
            OP_ASR:  result = DW'($signed(a) >>> cnt);
            OP_ASL:  result = a << cnt;
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_DEC:  result = a - ONE;
            OP_INC:  result = a + ONE;
            default: result = a;
        endcase
    end

    // Decide whether a branch opcode redirects the program counter.
    always_comb begin
        case (opc)
            OP_BRZ:  take = (a == '0);
            OP_BRN:  take = a[DW-1];
            OP_BR:   take = 1'b1;
            default: take = 1'b0;
        endcase
    end

    // R6: a zero shift count must leave the operand untouched.
    always_comb begin
        if ((opc == OP_ASR || opc == OP_ASL) && b[SH_W-1:0] == '0) begin
            a_r6_zero_count_keeps: assert (result == a)
                else $error("zero-count shift altered the operand");
        end
    end

endmodule

// File: rtl/octet_core.sv
// Byte-coded multicycle core: fetches 2- or 3-byte instructions over a
// one-cycle-latency byte memory port, resolves operands, loads memory
// operands, executes and writes back. Stops on unknown opcodes or
// forbidden operand modes. Assumes memory returns data the cycle after
// the address and accepts a write in the cycle the strobe is high.
module octet_core
    import octet_pkg::*;
#(
    parameter logic [DW-1:0] RESET_PC = '0
)(
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted,
    output logic          bad_opcode,
    output logic          bad_operand
);

    localparam logic [DW-1:0] LEN2 = DW'(2);
    localparam logic [DW-1:0] LEN3 = DW'(3);

    st_t              state;
    logic [DW-1:0]    pc;
    logic [DW-1:0]    gpr   [2];
    logic [DW-1:0]    ibuf  [IBYTES];
    logic [DW-1:0]    ldval [NOPND];
    logic [IDX_W-1:0] idx;
    logic             ld_idx;

    dec_t             dec;
    logic [DW-1:0]    next_pc;
    amode_t           mode   [NOPND];
    logic             is_mem [NOPND];
    logic [DW-1:0]    ea     [NOPND];
    logic [DW-1:0]    dval   [NOPND];
    logic [DW-1:0]    val    [NOPND];
    logic             need_ld [NOPND];
    logic [DW-1:0]    result;
    logic             take;
    logic             illegal;
    logic [DW-1:0]    target;
    amode_t           tgt_mode;

    // Decode the held opcode and the address of the following instruction.
    always_comb begin
        dec     = decode(ibuf[0]);
        next_pc = pc + (dec.three_byte ? LEN3 : LEN2);
    end

    // One resolver per operand byte.
    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
        opnd_resolve u_res (
            .opnd       (ibuf[k+1]),
            .r0         (gpr[0]),
            .r1         (gpr[1]),
            .next_pc    (next_pc),
            .mode       (mode[k]),
            .is_mem     (is_mem[k]),
            .ea         (ea[k]),
            .direct_val (dval[k])
        );

        // Pick the loaded byte for memory operands, the direct value otherwise.
        always_comb begin
            val[k]     = is_mem[k] ? ldval[k] : dval[k];
            need_ld[k] = (k == 0 ? dec.rd1 : dec.rd2) && is_mem[k];
        end
    end

    exec_unit u_exec (
        .opc    (ibuf[0]),
        .a      (val[0]),
        .b      (val[1]),
        .result (result),
        .take   (take)
    );

    // Find the branch target and flag operand modes the opcode forbids.
    always_comb begin
        target   = dec.tgt_on2 ? ea[1]   : ea[0];
        tgt_mode = dec.tgt_on2 ? mode[1] : mode[0];
        illegal  = (dec.wr1 && mode[0] == AM_IMM)
                || (dec.reg_dst && is_mem[0])
                || (dec.is_br && tgt_mode != AM_PCR);
    end

    // Drive the memory port from the current phase.
    always_comb begin
        case (state)
            ST_FETCH: mem_addr = pc + DW'(idx);
            ST_LOAD:  mem_addr = ea[ld_idx];
            ST_EXEC:  mem_addr = ea[0];
            default:  mem_addr = pc;
        endcase
        mem_we    = (state == ST_EXEC) && dec.wr1 && is_mem[0];
        mem_wdata = result;
        halted    = (state == ST_HALT);
    end

    // Sequencer: fetch, check, load, execute and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_FETCH;
            pc          <= RESET_PC;
            idx         <= '0;
            ld_idx      <= 1'b0;
            bad_opcode  <= 1'b0;
            bad_operand <= 1'b0;
            for (int i = 0; i < 2; i++)      gpr[i]   <= '0;
            for (int i = 0; i < IBYTES; i++) ibuf[i]  <= '0;
            for (int i = 0; i < NOPND; i++)  ldval[i] <= '0;
        end else begin
            case (state)
                ST_FETCH: state <= ST_FWAIT;
                ST_FWAIT: begin
                    ibuf[idx] <= mem_rdata;
                    if (idx == '0) begin
                        if (!is_known(mem_rdata)) begin
                            bad_opcode <= 1'b1;
                            state      <= ST_HALT;
                        end else begin
                            idx   <= IDX_W'(1);
                            state <= ST_FETCH;
                        end
                    end else if (idx == IDX_W'(1) && dec.three_byte) begin
                        idx   <= IDX_W'(2);
                        state <= ST_FETCH;
                    end else begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (illegal) begin
                        bad_operand <= 1'b1;
                        state       <= ST_HALT;
                    end else if (need_ld[0]) begin
                        ld_idx <= 1'b0;
                        state  <= ST_LOAD;
                    end else if (need_ld[1]) begin
                        ld_idx <= 1'b1;
                        state  <= ST_LOAD;
                    end else begin
                        state <= ST_EXEC;
                    end
                end
                ST_LOAD: state <= ST_LWAIT;
                ST_LWAIT: begin
                    ldval[ld_idx] <= mem_rdata;
                    if (!ld_idx && need_ld[1]) begin
                        ld_idx <= 1'b1;
                        state  <= ST_LOAD;
                    end else begin
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (dec.wr1 && mode[0] == AM_REG) gpr[ibuf[1][0]] <= result;
                    pc    <= (dec.is_br && take) ? target : next_pc;
                    idx   <= '0;
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // R9: once stopped, the core stays stopped until reset.
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: a stopped core never strobes a write.
    a_r9_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R9: execution only ever happens for an implemented opcode.
    a_r9_exec_known: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> dec.known);

    // R10: a stop carries exactly one cause.
    a_r10_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (bad_opcode ^ bad_operand));

    // R11: a write strobe lasts a single cycle.
    a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2: the program counter only advances at the end of an instruction.
    a_r2_pc_moves_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> $stable(pc));

endmodule

// File: tb/test_octet_core.sv
// Bench: assembles small programs, runs an instruction-level model of
// them, and compares every memory write and the final memory image,
// halt state and cause flags against it.
module test_octet_core;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 5000;

    localparam logic [7:0] K_MOV = 8'd8,  K_ASR = 8'd10, K_ASL = 8'd11;
    localparam logic [7:0] K_ADD = 8'd12, K_SUB = 8'd13, K_DEC = 8'd14;
    localparam logic [7:0] K_INC = 8'd15, K_BRZ = 8'd48, K_BRN = 8'd49;
    localparam logic [7:0] K_BR  = 8'd50, K_STOP = 8'hFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we, halted, bad_opcode, bad_operand;

    always #(CLK_PERIOD/2) clk = ~clk;

    octet_core i_octet_core (
        .clk (clk), .rst_n (rst_n),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we),
        .mem_rdata (mem_rdata),
        .halted (halted), .bad_opcode (bad_opcode), .bad_operand (bad_operand)
    );

    logic [7:0] ram [256];
    logic [7:0] img [256];
    logic [7:0] mm  [256];
    logic [7:0] mr  [2];
    logic [7:0] exp_a [$];
    logic [7:0] exp_d [$];
    int         checks = 0;
    int         errors = 0;
    int         pa = 0;
    bit         running = 1'b0;
    string      cur_tag = "";
    longint     cycles = 0;

    // Memory with one-cycle read latency.
    always @(posedge clk) begin
        mem_rdata <= ram[mem_addr];
        if (mem_we) ram[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    // Compare every write against the model's queue.
    always @(negedge clk) begin
        if (running && rst_n && mem_we) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R11", {cur_tag, " unexpected write"}, int'(mem_addr), 0);
            end else begin
                logic [7:0] ea, ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                check(mem_addr == ea, cur_tag, "write address", int'(mem_addr), int'(ea));
                check(mem_wdata == ed, cur_tag, "write data", int'(mem_wdata), int'(ed));
            end
        end
    end

    // Operand byte encoders.
    function automatic logic [7:0] f_imm(input int v); return {2'b00, 6'(v)}; endfunction
    function automatic logic [7:0] f_reg(input int n); return {2'b01, 5'd0, 1'(n)}; endfunction
    function automatic logic [7:0] f_idx(input int n, input int off);
        return {2'b10, 5'(off), 1'(n)};
    endfunction
    function automatic logic [7:0] f_pcr(input int d); return {2'b11, 6'(d)}; endfunction

    task automatic emit(input logic [7:0] b); img[pa] = b; pa++; endtask
    task automatic i3(input logic [7:0] op, input logic [7:0] x, input logic [7:0] y);
        emit(op); emit(x); emit(y);
    endtask
    task automatic i2(input logic [7:0] op, input logic [7:0] x);
        emit(op); emit(x);
    endtask
    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        pa = 0;
    endtask

    // Model: effective address and value of an operand byte.
    function automatic logic [7:0] m_ea(input logic [7:0] b, input logic [7:0] npc);
        if (b[7:6] == 2'b10) return mr[b[0]] + {3'b000, b[5:1]};
        return npc + {{2{b[5]}}, b[5:0]};
    endfunction
    function automatic logic [7:0] m_val(input logic [7:0] b, input logic [7:0] npc);
        case (b[7:6])
            2'b00:   return {{2{b[5]}}, b[5:0]};
            2'b01:   return mr[b[0]];
            default: return mm[m_ea(b, npc)];
        endcase
    endfunction

    // Instruction-level model run over mm; fills the expected write queue.
    task automatic run_model(output bit e_opc, output bit e_opr);
        logic [7:0] pc, op, b1, b2, npc, a, bv, res, tb;
        bit three, wr, brn;
        e_opc = 0; e_opr = 0;
        pc = 8'h00; mr[0] = 8'h00; mr[1] = 8'h00;
        for (int step = 0; step < 4000; step++) begin
            op = mm[pc];
            if (!(op inside {8, 10, 11, 12, 13, 14, 15, 48, 49, 50})) begin
                e_opc = 1; return;
            end
            three = !(op inside {14, 15, 50});
            b1 = mm[8'(pc + 8'd1)];
            b2 = mm[8'(pc + 8'd2)];
            npc = pc + (three ? 8'd3 : 8'd2);
            wr  = op inside {8, 10, 11, 12, 13, 14, 15};
            brn = op inside {48, 49, 50};
            tb  = (op == 50) ? b1 : b2;
            if ((wr && b1[7:6] == 2'b00) || (op inside {12, 13} && b1[7]) ||
                (brn && tb[7:6] != 2'b11)) begin
                e_opr = 1; return;
            end
            a  = m_val(b1, npc);
            bv = three ? m_val(b2, npc) : 8'h00;
            res = a;
            case (op)
                8:  res = bv;
                10: for (int k = 0; k < int'(bv[2:0]); k++) res = {res[7], res[7:1]};
                11: for (int k = 0; k < int'(bv[2:0]); k++) res = {res[6:0], 1'b0};
                12: res = a + bv;
                13: res = a - bv;
                14: res = a - 8'd1;
                15: res = a + 8'd1;
                default: ;
            endcase
            if (wr) begin
                if (b1[7:6] == 2'b01) mr[b1[0]] = res;
                else begin
                    mm[m_ea(b1, npc)] = res;
                    exp_a.push_back(m_ea(b1, npc));
                    exp_d.push_back(res);
                end
            end
            if ((op == 50) || (op == 48 && a == 8'h00) || (op == 49 && a[7]))
                pc = m_ea(tb, npc);
            else
                pc = npc;
        end
    endtask

    // Load the assembled image, reset the core, run it and compare.
    task automatic run_prog(input string tag);
        bit e_opc, e_opr;
        logic [7:0] held;
        int cyc, diff;
        cur_tag = tag;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin ram[i] = img[i]; mm[i] = img[i]; end
        exp_a.delete(); exp_d.delete();
        run_model(e_opc, e_opr);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(mem_addr == 8'h00, "R1", "first fetch address", int'(mem_addr), 0);
        check(mem_we == 1'b0, "R1", "write strobe in reset", int'(mem_we), 0);
        check({halted, bad_opcode, bad_operand} == 3'b000, "R1", "status in reset",
              int'({halted, bad_opcode, bad_operand}), 0);
        rst_n = 1'b1;
        running = 1'b1;
        cyc = 0;
        while (!halted && cyc < RUN_LIMIT) begin @(negedge clk); cyc++; end
        check(halted == 1'b1, tag, "program reached a stop", int'(halted), 1);
        held = mem_addr;
        repeat (20) @(negedge clk);
        check(mem_addr == held && halted, "R9", "no fetch after stop", int'(mem_addr), int'(held));
        check(bad_opcode == e_opc, "R9", {tag, " unknown-opcode flag"}, int'(bad_opcode), int'(e_opc));
        check(bad_operand == e_opr, "R10", {tag, " operand flag"}, int'(bad_operand), int'(e_opr));
        check(exp_a.size() == 0, "R11", {tag, " writes outstanding"}, exp_a.size(), 0);
        diff = 0;
        for (int i = 0; i < 256; i++) if (ram[i] !== mm[i]) diff++;
        check(diff == 0, tag, "final memory bytes differing", diff, 0);
        running = 1'b0;
    endtask

    initial begin
        // Arithmetic, moves, shifts and all four modes; R2 R3 R4 R5 R6 R7.
        clear_img();
        i3(K_MOV, f_reg(1), f_imm(1));      i3(K_ASL, f_reg(1), f_imm(7));
        i3(K_MOV, f_reg(0), f_imm(-5));     i3(K_MOV, f_idx(1, 0), f_reg(0));
        i3(K_ADD, f_reg(0), f_imm(20));     i3(K_MOV, f_idx(1, 1), f_reg(0));
        i3(K_SUB, f_reg(0), f_idx(1, 0));   i3(K_MOV, f_idx(1, 2), f_reg(0));
        i3(K_MOV, f_reg(0), f_imm(-32));    i3(K_ASR, f_reg(0), f_imm(2));
        i3(K_MOV, f_idx(1, 3), f_reg(0));   i3(K_ASL, f_reg(0), f_imm(9));
        i3(K_MOV, f_idx(1, 4), f_reg(0));   i3(K_ASR, f_reg(0), f_imm(8));
        i3(K_MOV, f_idx(1, 5), f_reg(0));   i2(K_INC, f_idx(1, 5));
        i2(K_DEC, f_idx(1, 0));             i3(K_MOV, f_reg(0), f_pcr(-2));
        i3(K_MOV, f_idx(1, 31), f_reg(0));  i3(K_SUB, f_reg(1), f_imm(-1));
        i2(K_INC, f_reg(1));                i2(K_DEC, f_reg(0));
        i3(K_MOV, f_pcr(20), f_reg(0));     i3(K_ASL, f_idx(1, 4), f_imm(1));
        i3(K_MOV, f_reg(0), f_reg(1));      i3(K_MOV, f_idx(0, 6), f_imm(9));
        emit(K_STOP);
        run_prog("R2 R3 R4 R5 R6 R7");

        // Countdown loop and taken / not-taken branches; R8.
        clear_img();
        i3(K_MOV, f_reg(1), f_imm(1));      i3(K_ASL, f_reg(1), f_imm(7));
        i3(K_MOV, f_reg(0), f_imm(4));
        i2(K_INC, f_idx(1, 0));             i2(K_DEC, f_reg(0));
        i3(K_BRZ, f_reg(0), f_pcr(2));      i2(K_BR, f_pcr(-9));
        i3(K_MOV, f_reg(0), f_imm(-2));     i3(K_BRN, f_reg(0), f_pcr(3));
        i3(K_MOV, f_idx(1, 1), f_imm(7));   i3(K_BRN, f_idx(1, 0), f_pcr(3));
        i3(K_MOV, f_idx(1, 2), f_reg(0));   i3(K_BRZ, f_imm(0), f_pcr(3));
        i3(K_MOV, f_idx(1, 3), f_reg(0));   emit(K_STOP);
        run_prog("R8");

        // Unknown opcode after valid work; R9.
        clear_img();
        i3(K_MOV, f_reg(0), f_imm(3));      i2(K_INC, f_reg(0));
        i3(K_MOV, f_pcr(20), f_reg(0));     emit(8'd9);
        i3(K_MOV, f_pcr(10), f_reg(0));
        run_prog("R9");

        // Memory destination for an add; R10.
        clear_img();
        i3(K_MOV, f_reg(1), f_imm(1));      i3(K_ADD, f_idx(1, 0), f_imm(1));
        i3(K_MOV, f_pcr(10), f_reg(1));
        run_prog("R10");

        // Immediate destination for a move; R10.
        clear_img();
        i3(K_MOV, f_pcr(10), f_reg(0));     i3(K_MOV, f_imm(3), f_reg(0));
        i3(K_MOV, f_pcr(10), f_reg(0));
        run_prog("R10");

        // Branch target given in register mode; R10.
        clear_img();
        i2(K_INC, f_reg(0));                i2(K_BR, f_reg(0));
        i3(K_MOV, f_pcr(10), f_reg(0));
        run_prog("R10");

        // PC-relative memory destination for a subtract; R10.
        clear_img();
        i3(K_SUB, f_pcr(4), f_imm(1));      emit(K_STOP);
        run_prog("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule